// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the control-register side of taking an exception or interrupt on a 32-bit processor core. When the core accepts an event, it presents a one-cycle accept strobe, a 3-bit event class, a 5-bit cause code, the program counter of the faulting or interrupted instruction and the current status word. On the next clock edge the block has updated the status word, the saved-status and break-status copies, the exception-cause register, the TLB-miscellaneous flags and the two return-address registers. It also emits a one-cycle redirect carrying the vector address the fetch unit must jump to.

What gets saved depends on the event class and on whether the exception-handler flag was already set in the incoming status. A TLB miss inside a handler is treated as a double miss: the first handler's saved state is preserved and the event goes to the general vector, while a first miss goes to its own fast vector. Breakpoints record their state in a separate register pair, so a debugger can stop inside an ordinary handler. An unknown class code is flagged on a sticky error output and changes nothing else.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Every accepted event of a valid class (codes 0 to 4) drives status_o to status_i with bit 0 (previous interrupt enable) and bit 1 (user mode) cleared; all other bits follow the rules below or are copied from status_i.
- R2: Every accepted valid event writes cause_i into bits [6:2] of cause_o, and every other bit of cause_o keeps its previous value.
- R3: Class 0 (interrupt) copies status_i to estatus_o, sets status bit 3 (interrupt handler), leaves bit 2 as in status_i, loads ea_o with pc_i+4 and redirects to the general vector.
- R4: Class 1 (TLB miss) with status_i bit 2 (exception handler, EH) clear copies status_i to estatus_o, sets EH, clears tlbmisc bit 1 (double miss), sets tlbmisc bit 0 (write in progress), loads ea_o with pc_i+4 and redirects to the fast TLB-miss vector.
- R5: Class 1 with EH set keeps estatus_o and ea_o, sets tlbmisc bit 1, keeps tlbmisc bit 0, sets EH and redirects to the general vector.
- R6: Class 2 (TLB permission fault) copies status_i to estatus_o and pc_i+4 to ea_o whatever EH is, sets EH and redirects to the general vector.
- R7: Class 3 (supervisor, illegal instruction or trap) copies status_i to estatus_o and pc_i+4 to ea_o only when EH is clear in status_i; it always sets EH and redirects to the general vector.
- R8: Class 4 (breakpoint) copies status_i to bstatus_o and pc_i+4 to ba_o only when EH is clear, leaves estatus_o and ea_o unchanged, always sets EH and redirects to the general vector.
- R9: redir_vld_o is high for exactly the one cycle after an accepted valid event, with redir_pc_o holding the vector; it is low in all other cycles.
- R10: An accept with class 5, 6 or 7 sets err_o, which stays high until reset, and leaves every other output unchanged with no redirect.
- R11: After reset every register output is zero, err_o is low and redir_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | One-cycle strobe: an event is being taken |
| cls_i | input | 3 | Event class code |
| cause_i | input | 5 | Cause code recorded in the cause register |
| pc_i | input | 32 | Address of the interrupted instruction |
| status_i | input | 32 | Current status word |
| status_o | output | 32 | Updated status word |
| estatus_o | output | 32 | Saved status for ordinary exceptions |
| bstatus_o | output | 32 | Saved status for breakpoints |
| cause_o | output | 32 | Exception-cause register |
| tlbmisc_o | output | 32 | TLB flags: bit 0 write in progress, bit 1 double miss |
| ea_o | output | 32 | Exception return address |
| ba_o | output | 32 | Breakpoint return address |
| redir_pc_o | output | 32 | Vector address for the fetch unit |
| redir_vld_o | output | 1 | Redirect strobe |
| err_o | output | 1 | Sticky unknown-class flag |

## Verification
Every register is updated from a single next-value computation, so a wrong decision about nesting or class appears on the outputs one clock after the accept strobe. It shows as a saved-status or return address that was overwritten when it should have been kept, or the reverse, or as a redirect to the wrong vector. Because the saved registers persist, a wrong overwrite also stays visible until the next event of the same kind. Sequences that move from EH clear to EH set show this.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int ARCH_W    = 32;
    localparam int CAUSE_W   = 5;
    localparam int CAUSE_LSB = 2;
    localparam int CLS_W     = 3;

    localparam int ST_PIE = 0;
    localparam int ST_U   = 1;
    localparam int ST_EH  = 2;
    localparam int ST_IH  = 3;

    localparam int TM_WR  = 0;
    localparam int TM_DBL = 1;

    typedef enum logic [CLS_W-1:0] {
        CLS_IRQ      = 3'd0,
        CLS_TLB_MISS = 3'd1,
        CLS_TLB_PERM = 3'd2,
        CLS_FAULT    = 3'd3,
        CLS_BREAK    = 3'd4
    } exc_cls_e;

    typedef struct packed {
        logic irq;
        logic miss;
        logic perm;
        logic fault;
        logic brk;
        logic bad;
    } cls_dec_t;

    typedef struct packed {
        logic [ARCH_W-1:0] status;
        logic [ARCH_W-1:0] estatus;
        logic [ARCH_W-1:0] bstatus;
        logic [ARCH_W-1:0] cause;
        logic [ARCH_W-1:0] tlbmisc;
        logic [ARCH_W-1:0] ea;
        logic [ARCH_W-1:0] ba;
        logic [ARCH_W-1:0] rpc;
        logic              rvld;
        logic              err;
    } entry_state_t;
endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
    import exc_entry_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output cls_dec_t         dec_o
);
    always_comb begin
        dec_o = '0;
        case (cls_i)
            CLS_IRQ:      dec_o.irq   = 1'b1;
            CLS_TLB_MISS: dec_o.miss  = 1'b1;
            CLS_TLB_PERM: dec_o.perm  = 1'b1;
            CLS_FAULT:    dec_o.fault = 1'b1;
            CLS_BREAK:    dec_o.brk   = 1'b1;
            default:      dec_o.bad   = 1'b1;
        endcase
    end
endmodule

// File: rtl/exc_entry_next.sv
module exc_entry_next
    import exc_entry_pkg::*;
#(
    parameter logic [ARCH_W-1:0] GEN_VEC = 32'h0000_0120,
    parameter logic [ARCH_W-1:0] TLB_VEC = 32'h0000_0100
) (
    input  entry_state_t      cur_i,
    input  logic              accept_i,
    input  cls_dec_t          dec_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [ARCH_W-1:0] pc_i,
    input  logic [ARCH_W-1:0] status_i,
    output entry_state_t      nxt_o
);
    localparam logic [ARCH_W-1:0] PC_STEP = ARCH_W'(4);

    logic              eh_in;
    logic [ARCH_W-1:0] ret_addr;
    logic [ARCH_W-1:0] base_status;

    always_comb begin
        eh_in       = status_i[ST_EH];
        ret_addr    = pc_i + PC_STEP;
        base_status = status_i;
        base_status[ST_PIE] = 1'b0;
        base_status[ST_U]   = 1'b0;

        nxt_o      = cur_i;
        nxt_o.rvld = 1'b0;

        if (accept_i && dec_i.bad) begin
            nxt_o.err = 1'b1;
        end else if (accept_i) begin
            nxt_o.status = base_status;
            nxt_o.cause[CAUSE_LSB +: CAUSE_W] = cause_i;
            nxt_o.rvld = 1'b1;
            nxt_o.rpc  = GEN_VEC;

            if (dec_i.irq) begin
                nxt_o.estatus       = status_i;
                nxt_o.ea            = ret_addr;
                nxt_o.status[ST_IH] = 1'b1;
            end else begin
                nxt_o.status[ST_EH] = 1'b1;
            end

            if (dec_i.miss) begin
                if (!eh_in) begin
                    nxt_o.estatus         = status_i;
                    nxt_o.ea              = ret_addr;
                    nxt_o.tlbmisc[TM_DBL] = 1'b0;
                    nxt_o.tlbmisc[TM_WR]  = 1'b1;
                    nxt_o.rpc             = TLB_VEC;
                end else begin
                    nxt_o.tlbmisc[TM_DBL] = 1'b1;
                end
            end

            if (dec_i.perm || (dec_i.fault && !eh_in)) begin
                nxt_o.estatus = status_i;
                nxt_o.ea      = ret_addr;
            end

            if (dec_i.brk && !eh_in) begin
                nxt_o.bstatus = status_i;
                nxt_o.ba      = ret_addr;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] GEN_VEC = 32'h0000_0120,
    parameter logic [31:0] TLB_VEC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept_i,
    input  logic [2:0]  cls_i,
    input  logic [4:0]  cause_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] status_i,
    output logic [31:0] status_o,
    output logic [31:0] estatus_o,
    output logic [31:0] bstatus_o,
    output logic [31:0] cause_o,
    output logic [31:0] tlbmisc_o,
    output logic [31:0] ea_o,
    output logic [31:0] ba_o,
    output logic [31:0] redir_pc_o,
    output logic        redir_vld_o,
    output logic        err_o
);
    localparam logic [ARCH_W-1:0] CAUSE_MASK =
        ARCH_W'(((1 << CAUSE_W) - 1) << CAUSE_LSB);

    cls_dec_t     dec;
    entry_state_t st_d;
    entry_state_t st_q;

    exc_class_decode u_dec (
        .cls_i (cls_i),
        .dec_o (dec)
    );

    exc_entry_next #(
        .GEN_VEC (GEN_VEC),
        .TLB_VEC (TLB_VEC)
    ) u_next (
        .cur_i    (st_q),
        .accept_i (accept_i),
        .dec_i    (dec),
        .cause_i  (cause_i),
        .pc_i     (pc_i),
        .status_i (status_i),
        .nxt_o    (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o    = st_q.status;
    assign estatus_o   = st_q.estatus;
    assign bstatus_o   = st_q.bstatus;
    assign cause_o     = st_q.cause;
    assign tlbmisc_o   = st_q.tlbmisc;
    assign ea_o        = st_q.ea;
    assign ba_o        = st_q.ba;
    assign redir_pc_o  = st_q.rpc;
    assign redir_vld_o = st_q.rvld;
    assign err_o       = st_q.err;

    AST_CLEAR_PIE_U: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !dec.bad) |=> (!status_o[ST_PIE] && !status_o[ST_U])); // R1

    AST_CAUSE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !dec.bad) |=> (cause_o[CAUSE_LSB +: CAUSE_W] == $past(cause_i))); // R2

    AST_CAUSE_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> ((cause_o & ~CAUSE_MASK) == $past(cause_o & ~CAUSE_MASK))); // R2

    AST_DOUBLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && dec.miss && status_i[ST_EH]) |=>
        ($stable(estatus_o) && $stable(ea_o) && tlbmisc_o[TM_DBL])); // R5

    AST_VECTOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld_o |-> (redir_pc_o == GEN_VEC || redir_pc_o == TLB_VEC)); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> !redir_vld_o); // R9

    AST_BAD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && dec.bad) |=> (err_o && !redir_vld_o && $stable(status_o) && $stable(ea_o))); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam logic [31:0] GV = 32'h0000_0180;
    localparam logic [31:0] TV = 32'h0000_0040;
    localparam int NV = 10;

    // {class[71:69], status[68:37], pc[36:5], cause[4:0]}
    localparam logic [71:0] TBL [0:NV-1] = '{
        {3'd0, 32'h0000_0003, 32'h0000_1000, 5'd1},
        {3'd1, 32'h0000_0001, 32'h0000_2000, 5'd12},
        {3'd1, 32'h0000_0007, 32'h0000_2100, 5'd12},
        {3'd2, 32'h0000_0005, 32'h0000_3000, 5'd14},
        {3'd3, 32'h0000_0003, 32'h0000_4000, 5'd9},
        {3'd3, 32'h0000_0006, 32'h0000_4400, 5'd5},
        {3'd4, 32'h0000_0011, 32'h0000_5000, 5'd7},
        {3'd4, 32'h0000_0014, 32'h0000_5400, 5'd7},
        {3'd1, 32'h0000_0000, 32'h0000_6000, 5'd31},
        {3'd0, 32'h0000_00F2, 32'hFFFF_FFFC, 5'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic accept = 1'b0;
    logic [2:0]  cls = '0;
    logic [4:0]  cause = '0;
    logic [31:0] pc = '0;
    logic [31:0] status = '0;
    logic [31:0] st_o, est_o, bst_o, cau_o, tm_o, ea_o, ba_o, rpc_o;
    logic        rvld_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_st, m_est, m_bst, m_cau, m_tm, m_ea, m_ba, m_rpc;

    always #2 clk = ~clk;

    exc_entry_ctrl #(.GEN_VEC(GV), .TLB_VEC(TV)) uut (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .cls_i(cls),
        .cause_i(cause), .pc_i(pc), .status_i(status),
        .status_o(st_o), .estatus_o(est_o), .bstatus_o(bst_o),
        .cause_o(cau_o), .tlbmisc_o(tm_o), .ea_o(ea_o), .ba_o(ba_o),
        .redir_pc_o(rpc_o), .redir_vld_o(rvld_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] c, input logic [31:0] s,
                         input logic [31:0] p, input logic [4:0] k);
        logic [31:0] ns;
        ns = s;
        ns[0] = 1'b0;
        ns[1] = 1'b0;
        m_cau[6:2] = k;
        m_rpc = GV;
        case (c)
            3'd0: begin m_est = s; m_ea = p + 4; ns[3] = 1'b1; end
            3'd1: begin
                ns[2] = 1'b1;
                if (!s[2]) begin
                    m_est = s; m_ea = p + 4; m_tm[1] = 1'b0; m_tm[0] = 1'b1; m_rpc = TV;
                end else m_tm[1] = 1'b1;
            end
            3'd2: begin m_est = s; m_ea = p + 4; ns[2] = 1'b1; end
            3'd3: begin if (!s[2]) begin m_est = s; m_ea = p + 4; end ns[2] = 1'b1; end
            default: begin if (!s[2]) begin m_bst = s; m_ba = p + 4; end ns[2] = 1'b1; end
        endcase
        m_st = ns;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R1 status"},   st_o,  m_st);
        chk({tag, " estatus"},     est_o, m_est);
        chk({tag, " R8 bstatus"},  bst_o, m_bst);
        chk({tag, " R2 cause"},    cau_o, m_cau);
        chk({tag, " tlbmisc"},     tm_o,  m_tm);
        chk({tag, " ea"},          ea_o,  m_ea);
        chk({tag, " R8 ba"},       ba_o,  m_ba);
    endtask

    task automatic fire(input logic [2:0] c, input logic [31:0] s,
                        input logic [31:0] p, input logic [4:0] k);
        @(negedge clk);
        cls = c; status = s; pc = p; cause = k; accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tg;
        m_st = '0; m_est = '0; m_bst = '0; m_cau = '0;
        m_tm = '0; m_ea = '0; m_ba = '0; m_rpc = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        compare_all("R11 reset");
        chk("R11 vld", {31'd0, rvld_o}, 32'd0);
        chk("R11 err", {31'd0, err_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] c; logic [31:0] s, p; logic [4:0] k;
            {c, s, p, k} = TBL[i];
            model(c, s, p, k);
            fire(c, s, p, k);
            case (c)
                3'd0: tg = "R3";
                3'd1: tg = s[2] ? "R5" : "R4";
                3'd2: tg = "R6";
                3'd3: tg = "R7";
                default: tg = "R8";
            endcase
            compare_all(tg);
            chk({tg, " R9 vld"}, {31'd0, rvld_o}, 32'd1);
            chk({tg, " R9 vector"}, rpc_o, m_rpc);
            @(negedge clk);
            chk("R9 vld drops", {31'd0, rvld_o}, 32'd0);
        end

        // R9: idle cycles with class inputs toggling, no accept
        cls = 3'd1; status = 32'h0; pc = 32'h1234;
        @(negedge clk);
        @(negedge clk);
        chk("R9 idle vld", {31'd0, rvld_o}, 32'd0);
        compare_all("R9 idle");

        // R10: unknown class
        fire(3'd6, 32'h0000_0003, 32'h0000_7000, 5'd3);
        chk("R10 err", {31'd0, err_o}, 32'd1);
        chk("R10 vld", {31'd0, rvld_o}, 32'd0);
        compare_all("R10 unchanged");
        fire(3'd7, 32'h0000_0000, 32'h0000_7100, 5'd4);
        compare_all("R10 unchanged 7");
        model(3'd2, 32'h0000_0001, 32'h0000_8000, 5'd15);
        fire(3'd2, 32'h0000_0001, 32'h0000_8000, 5'd15);
        chk("R10 err sticky", {31'd0, err_o}, 32'd1);
        compare_all("R6 after err");

        // R11: reset clears sticky error and registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        m_st = '0; m_est = '0; m_bst = '0; m_cau = '0;
        m_tm = '0; m_ea = '0; m_ba = '0;
        chk("R11 err clear", {31'd0, err_o}, 32'd0);
        compare_all("R11 re-reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule